// File: doc/BRIEF.md
# Synchronous Serial Port Master with Frame FIFOs

This block is a memory-mapped serial port controller that drives a four-wire synchronous link as the clock master. Software writes frames into an eight-entry transmit queue through a data register. The serial engine takes frames one at a time and shifts them out most significant bit first while it shifts a frame in. Each received frame lands in an eight-entry receive queue that the same data register drains.

Frame length runs from 4 to 16 bits. Idle clock level and sampling edge are selectable. The bit rate comes from an even prescaler multiplied by a second divider. Three interrupt sources cover a receive queue that is filling, a transmit queue that is draining, and a lost frame on receive. An internal loopback path lets the port test itself without the external pins. Chip select is generated outside the block.

Top module: `ssp_master`

## Requirements
- R1: After reset every register reads 0, except status, which reads 0x03. `sclk`, `mosi` and all interrupt outputs are low.
- R2: Frame width is (control0[3:0] + 1) bits. Values below 3 are treated as 3. Frames are sent most significant bit first. The received word is right-aligned with its upper bits zero. In loopback, a frame reads back equal to the written word masked to the frame width.
- R3: Control0 bit 7 (polarity) sets the idle level of `sclk`. Control0 bit 6 (phase) selects where input is sampled. With phase 0 it is sampled on the first edge of each bit and output changes on the second edge. With phase 1 output changes on the first edge and input is sampled on the second.
- R4: Each `sclk` half period lasts (prescale/2)×(control0[15:8]+1) clock cycles. The prescale register is at 0x10 and its bit 0 is forced to 0. A prescale of 0 acts as 2.
- R5: Each queue holds 8 frames. A data write (0x08) to a full transmit queue is dropped. A data read from an empty receive queue returns 0.
- R6: Status (0x0C) bits: 0 = transmit queue empty, 1 = transmit queue not full, 2 = receive queue not empty, 3 = receive queue full, 4 = busy.
- R7: A frame that completes while the receive queue holds 8 frames is discarded and sets a sticky overrun flag. Any write to 0x14 clears the flag. When the flag is set and cleared in the same cycle, the set wins.
- R8: Control1 (0x04) bits 0/1/2 enable the receive, transmit and overrun interrupts. Receive fires when the receive queue holds 4 or more frames. Transmit fires when the transmit queue holds 4 or fewer. Overrun fires while the flag is set. Register 0x14 reads these three gated sources in bits 0/1/2, and `irq` is their OR.
- R9: With control1 bit 3 set, received bits come from the port's own `mosi`, and `miso` has no effect.
- R10: With control1 bit 4 (enable) clear, no frame starts, a running frame is abandoned, and `sclk` rests at the idle level.
- R11: Busy is set while a frame is shifting or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x08) |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_be | input | 2 | Byte lanes for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive level interrupt |
| irq_tx | output | 1 | Transmit level interrupt |
| irq_ror | output | 1 | Receive overrun interrupt |
| irq | output | 1 | OR of the three interrupts |

## Verification
Two events can land in the same cycle: a frame completing while the receive queue is full, and a software write to the clear register. The bench fills the receive queue and queues one more frame. It then holds a clear write on the bus every cycle while that frame shifts. Because every cycle carries a clear, the overrun interrupt can only be high at some sampled cycle if the set won over the simultaneous clear. The bench therefore expects one sample high, followed by low once the held clears act alone.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
    localparam int unsigned OFS_CTL0  = 'h00;
    localparam int unsigned OFS_CTL1  = 'h04;
    localparam int unsigned OFS_DATA  = 'h08;
    localparam int unsigned OFS_STAT  = 'h0C;
    localparam int unsigned OFS_PRESC = 'h10;
    localparam int unsigned OFS_INTS  = 'h14;

    localparam int unsigned C1_RXIE = 0;
    localparam int unsigned C1_TXIE = 1;
    localparam int unsigned C1_ORIE = 2;
    localparam int unsigned C1_LOOP = 3;
    localparam int unsigned C1_EN   = 4;

    localparam int unsigned C0_PHA = 6;
    localparam int unsigned C0_POL = 7;

    typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;

    typedef struct packed {
        logic [15:0] ctl0;
        logic [6:0]  ctl1;
        logic [7:0]  presc;
        logic        ovr;
    } regs_t;
endpackage

// File: rtl/ssp_fifo.sv
`timescale 1ns/1ps
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d = q;
        if (do_push) d.wp = bump(q.wp);
        if (do_pop)  d.rp = bump(q.rp);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wp] <= wdata;
    end

    assign rdata = mem_q[q.rp];
    assign count = q.cnt;

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH)); // R5
    AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> $stable(q.cnt)); // R5
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int MAXW = 16,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            loopback,
    input  logic [3:0]      size_m1,
    input  logic [CNTW-1:0] half_len,
    input  logic            tx_avail,
    input  logic [MAXW-1:0] tx_word,
    output logic            tx_pop,
    output logic            rx_done,
    output logic [MAXW-1:0] rx_word,
    output logic            active,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso
);
    localparam int BW = $clog2(MAXW+1);

    typedef struct packed {
        sh_state_e       state;
        logic [CNTW-1:0] cnt;
        logic [BW-1:0]   bits;
        logic            lead;
        logic            sclk;
        logic            mosi;
        logic            done;
        logic [MAXW-1:0] txsr;
        logic [MAXW-1:0] rxsr;
    } sh_st_t;

    sh_st_t q, d;
    logic din;

    assign din = loopback ? q.mosi : miso;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        tx_pop = 1'b0;
        case (q.state)
            SH_IDLE: begin
                d.sclk = cpol;
                if (enable && tx_avail) begin
                    tx_pop  = 1'b1;
                    d.state = SH_RUN;
                    d.cnt   = half_len;
                    d.bits  = BW'(size_m1) + BW'(1);
                    d.lead  = 1'b1;
                    d.rxsr  = '0;
                    if (!cpha) begin
                        d.mosi = tx_word[size_m1];
                        d.txsr = {tx_word[MAXW-2:0], 1'b0};
                    end else begin
                        d.txsr = tx_word;
                    end
                end
            end
            default: begin
                if (!enable) begin
                    d.state = SH_IDLE;
                    d.sclk  = cpol;
                end else if (q.cnt <= CNTW'(1)) begin
                    d.cnt  = half_len;
                    d.sclk = ~q.sclk;
                    if (q.lead) begin
                        d.lead = 1'b0;
                        if (!cpha) begin
                            d.rxsr = {q.rxsr[MAXW-2:0], din};
                        end else begin
                            d.mosi = q.txsr[size_m1];
                            d.txsr = {q.txsr[MAXW-2:0], 1'b0};
                        end
                    end else begin
                        d.lead = 1'b1;
                        if (cpha) d.rxsr = {q.rxsr[MAXW-2:0], din};
                        if (q.bits <= BW'(1)) begin
                            d.state = SH_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.bits = q.bits - BW'(1);
                            if (!cpha) begin
                                d.mosi = q.txsr[size_m1];
                                d.txsr = {q.txsr[MAXW-2:0], 1'b0};
                            end
                        end
                    end
                end else begin
                    d.cnt = q.cnt - CNTW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_done = q.done;
    assign rx_word = q.rxsr;
    assign active  = (q.state == SH_RUN);
    assign sclk    = q.sclk;
    assign mosi    = q.mosi;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SH_IDLE && $past(q.state == SH_IDLE) && $stable(cpol)) |-> q.sclk == cpol); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R2
    AST_DISABLED_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> q.state == SH_IDLE); // R10
endmodule

// File: rtl/ssp_master.sv
`timescale 1ns/1ps
module ssp_master
    import ssp_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_ror,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH+1);

    regs_t q, d;

    logic sel_ctl0, sel_ctl1, sel_data, sel_stat, sel_presc, sel_ints;
    assign sel_ctl0  = (bus_addr == ADDR_W'(OFS_CTL0));
    assign sel_ctl1  = (bus_addr == ADDR_W'(OFS_CTL1));
    assign sel_data  = (bus_addr == ADDR_W'(OFS_DATA));
    assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_presc = (bus_addr == ADDR_W'(OFS_PRESC));
    assign sel_ints  = (bus_addr == ADDR_W'(OFS_INTS));

    logic          tx_push, tx_pop, tx_full, tx_empty;
    logic [15:0]   tx_in, tx_head;
    logic [CW-1:0] tx_cnt;
    logic          rx_push, rx_pop, rx_full, rx_empty;
    logic [15:0]   rx_head;
    logic [CW-1:0] rx_cnt;
    logic          sh_done, sh_active;
    logic [15:0]   sh_word;
    logic          ovr_clr;

    assign tx_push = bus_wr && sel_data && (bus_be != 2'b00);
    assign tx_in   = bus_be[1] ? bus_wdata : {8'h00, bus_wdata[7:0]};
    assign rx_pop  = bus_rd && sel_data;
    assign rx_push = sh_done && !rx_full;
    assign ovr_clr = bus_wr && sel_ints;

    ssp_fifo #(.WIDTH(16), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_in), .pop(tx_pop),
        .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.WIDTH(16), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(sh_word), .pop(rx_pop),
        .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    logic [3:0]  size_m1;
    logic [6:0]  pre_half;
    logic [15:0] half_len;

    assign size_m1  = (q.ctl0[3:0] < 4'd3) ? 4'd3 : q.ctl0[3:0];
    assign pre_half = (q.presc[7:1] == 7'd0) ? 7'd1 : q.presc[7:1];
    assign half_len = 16'(pre_half) * (16'(q.ctl0[15:8]) + 16'd1);

    ssp_shifter #(.MAXW(16), .CNTW(16)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .enable(q.ctl1[C1_EN]), .cpol(q.ctl0[C0_POL]), .cpha(q.ctl0[C0_PHA]),
        .loopback(q.ctl1[C1_LOOP]), .size_m1(size_m1), .half_len(half_len),
        .tx_avail(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_done(sh_done), .rx_word(sh_word), .active(sh_active),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always_comb begin
        d = q;
        if (bus_wr && bus_be[0]) begin
            if (sel_ctl0)  d.ctl0[7:0] = bus_wdata[7:0];
            if (sel_ctl1)  d.ctl1      = bus_wdata[6:0];
            if (sel_presc) d.presc     = {bus_wdata[7:1], 1'b0};
        end
        if (bus_wr && bus_be[1] && sel_ctl0) d.ctl0[15:8] = bus_wdata[15:8];
        if (ovr_clr) d.ovr = 1'b0;
        if (sh_done && rx_full) d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic busy;
    assign busy    = sh_active || !tx_empty;
    assign irq_rx  = q.ctl1[C1_RXIE] && (rx_cnt >= CW'(THRESH));
    assign irq_tx  = q.ctl1[C1_TXIE] && (tx_cnt <= CW'(THRESH));
    assign irq_ror = q.ctl1[C1_ORIE] && q.ovr;
    assign irq     = irq_rx || irq_tx || irq_ror;

    always_comb begin
        bus_rdata = 16'h0000;
        if (sel_ctl0)  bus_rdata = q.ctl0;
        if (sel_ctl1)  bus_rdata = {9'd0, q.ctl1};
        if (sel_data)  bus_rdata = rx_empty ? 16'h0000 : rx_head;
        if (sel_stat)  bus_rdata = {11'd0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
        if (sel_presc) bus_rdata = {8'd0, q.presc};
        if (sel_ints)  bus_rdata = {13'd0, irq_ror, irq_tx, irq_rx};
    end

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_done && rx_full) |=> q.ovr); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovr && !ovr_clr) |=> q.ovr); // R7
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_done && rx_full && !rx_pop) |=> rx_full); // R7
endmodule

// File: tb/ssp_master_bench.sv
`timescale 1ns/1ps
module ssp_master_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        bus_wr = 0, bus_rd = 0;
    logic [4:0]  bus_addr = 0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic        sclk, mosi, irq_rx, irq_tx, irq_ror, irq;
    logic        miso_ext = 1'b0;

    ssp_master u_ssp_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso_ext),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ror(irq_ror), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = v; bus_be = 2'b11;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(5'h0C, s);
            if (!s[4]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] fmask(input int size);
        return 16'((32'd1 << size) - 1);
    endfunction

    function automatic logic [15:0] c0(input int scr, input int pol, input int pha, input int size);
        return 16'((scr << 8) | (pol << 7) | (pha << 6) | (size - 1));
    endfunction

    // bench slave model on the serial pins
    bit          ext_on = 0;
    logic        s_pol = 0, s_pha = 0, lead;
    int          s_size = 8;
    logic [15:0] s_tx = 0, s_rx = 0;
    time         t_last = 0, gmin = 0, gmax = 0;

    always @(sclk) begin
        if (ext_on) begin
            if (t_last != 0) begin
                if ($time - t_last < gmin) gmin = $time - t_last;
                if ($time - t_last > gmax) gmax = $time - t_last;
            end
            t_last = $time;
            lead = (sclk != s_pol);
            if (lead == !s_pha) s_rx = {s_rx[14:0], mosi};
            else begin
                miso_ext = s_tx[s_size-1];
                s_tx = s_tx << 1;
            end
        end
    end

    task automatic run_ext(input int pol, input int pha, input int size,
                           input logic [15:0] txw, input logic [15:0] slw);
        logic [15:0] v;
        wr(5'h04, 16'h0010);
        wr(5'h10, 16'h0004);
        wr(5'h00, c0(2, pol, pha, size));
        repeat (5) @(negedge clk);
        chk("R3 idle level", sclk, pol);
        s_pol = pol[0]; s_pha = pha[0]; s_size = size; s_tx = slw; s_rx = 0;
        if (pha == 0) begin miso_ext = s_tx[size-1]; s_tx = s_tx << 1; end
        t_last = 0; gmin = 1000000; gmax = 0;
        ext_on = 1;
        wr(5'h08, txw);
        wait_idle();
        ext_on = 0;
        rd(5'h08, v);
        chk("R3 master received", v, slw & fmask(size));
        chk("R3 slave received", s_rx & fmask(size), txw & fmask(size));
        chk("R4 min half period", 32'(gmin), 32'd24);
        chk("R4 max half period", 32'(gmax), 32'd24);
    endtask

    logic [15:0] v, expq[8];
    bit saw;

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(5'h00, v); chk("R1 ctl0", v, 0);
        rd(5'h04, v); chk("R1 ctl1", v, 0);
        rd(5'h0C, v); chk("R1 status", v, 16'h0003);
        rd(5'h10, v); chk("R1 prescale", v, 0);
        rd(5'h14, v); chk("R1 int status", v, 0);
        chk("R1 pins", {sclk, mosi, irq_rx, irq_tx, irq_ror, irq}, 0);
        rd(5'h08, v); chk("R5 empty read", v, 0);

        // R3/R4 external slave, all four modes
        run_ext(0, 0, 8,  16'h00A5, 16'h003C);
        run_ext(0, 1, 12, 16'h0B6D, 16'h0924);
        run_ext(1, 0, 8,  16'h0081, 16'h00F0);
        run_ext(1, 1, 16, 16'hC3A5, 16'h5A1E);

        // R2/R6/R9 random loopback with external input stuck high
        miso_ext = 1;
        for (int it = 0; it < 25; it++) begin
            int size, n;
            size = 4 + int'($urandom % 13);
            n = 1 + int'($urandom % 8);
            wr(5'h04, 16'h0018);
            wr(5'h10, 16'h0002);
            wr(5'h00, c0(int'($urandom % 3), int'($urandom % 2), int'($urandom % 2), size));
            repeat (3) @(negedge clk);
            for (int k = 0; k < n; k++) begin
                expq[k] = 16'($urandom);
                wr(5'h08, expq[k]);
            end
            wait_idle();
            rd(5'h0C, v);
            chk("R6 status after burst", v, 16'h0007 | ((n == 8) ? 16'h0008 : 16'h0000));
            for (int k = 0; k < n; k++) begin
                rd(5'h08, v);
                chk("R2 loopback frame", v, expq[k] & fmask(size));
            end
            rd(5'h0C, v); chk("R6 status drained", v, 16'h0003);
        end

        // R2 clamp of small size field, R9 zero frame with miso high
        wr(5'h00, 16'h0000);
        wr(5'h08, 16'h03A5); wait_idle();
        rd(5'h08, v); chk("R2 size clamp to 4", v, 16'h0005);
        wr(5'h00, c0(0, 0, 0, 8));
        wr(5'h08, 16'h0000); wait_idle();
        rd(5'h08, v); chk("R9 loopback ignores miso", v, 16'h0000);

        // R8/R10/R11 port disabled, fill transmit queue
        wr(5'h04, 16'h000F);
        chk("R8 tx irq on empty", irq_tx, 1);
        for (int k = 1; k <= 9; k++) begin
            wr(5'h08, 16'(k));
            chk("R8 tx irq threshold", irq_tx, (k <= 4) ? 1 : 0);
        end
        rd(5'h0C, v); chk("R5 R6 R11 full queue while disabled", v, 16'h0010);
        repeat (40) @(negedge clk);
        rd(5'h0C, v); chk("R10 nothing sent while disabled", v, 16'h0010);
        chk("R10 sclk idle", sclk, 0);
        wr(5'h04, 16'h001F);
        wait_idle();
        rd(5'h0C, v); chk("R6 R11 both queues full", v, 16'h000F);
        chk("R8 rx irq", irq_rx, 1);
        rd(5'h14, v); chk("R8 int status", v, 16'h0003);
        // R7 overrun
        wr(5'h08, 16'h00A1); wait_idle();
        chk("R7 overrun irq", irq_ror, 1);
        rd(5'h14, v); chk("R7 int status", v, 16'h0007);
        chk("R8 combined irq", irq, 1);
        for (int k = 1; k <= 8; k++) begin
            rd(5'h08, v);
            chk("R5 R7 kept frames", v, 16'(k));
            chk("R8 rx irq level", irq_rx, ((8 - k) >= 4) ? 1 : 0);
        end
        rd(5'h0C, v); chk("R7 overrun frame dropped", v, 16'h0003);
        chk("R7 flag sticky", irq_ror, 1);
        wr(5'h14, 16'h0000);
        chk("R7 clear", irq_ror, 0);

        // R7 set and clear in the same cycle
        wr(5'h04, 16'h000C);
        for (int k = 0; k < 8; k++) wr(5'h08, 16'(k));
        wr(5'h04, 16'h001C);
        wait_idle();
        wr(5'h08, 16'h00B2);
        saw = 0;
        @(negedge clk);
        bus_wr = 1; bus_addr = 5'h14; bus_wdata = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (irq_ror) saw = 1;
        end
        bus_wr = 0;
        chk("R7 set wins over clear", saw, 1);
        chk("R7 cleared afterwards", irq_ror, 0);
        for (int k = 0; k < 8; k++) rd(5'h08, v);
        rd(5'h0C, v); chk("R6 final status", v, 16'h0003);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule